// File: doc/BRIEF.md
# Transition-Triggered Read Sense SRAM Model

This block is a clocked, synthesizable model of one low-power static RAM die. The read path senses the array only when new data is asked for. On every clock it samples an active-low enable, an active-low write enable, an active-low output enable, an address and write data.

A read trigger is raised when the enable becomes active in read mode. A trigger is also raised when the address changes while the die is enabled in read mode. A trigger opens a sense window of `SENSE_CYC` cycles. At the end of that window the addressed word is loaded into an output latch. The latch keeps that value until the next sense completes, even if the stored word is rewritten in the meantime.

Triggers that arrive within the first `MERGE_CYC` cycles of a window are folded into the same sense, and the newest address wins. A trigger that arrives later starts a second sense before the first has settled. That read is marked as damaged: an error flag is set and the latch presents an all-ones word. Writes go straight into an internal array.

The die is meant to sit in a chip-level memory model. A surrounding testbench or controller uses it to study stale-data and skew effects of transition-sensed reads.

Top module: `trig_sense_sram`

## Requirements
- R1: While reset is high and on the cycle after it is released, `dq_oe` is 0, `rd_err` is 0 and `dq_out` is all zeros.
- R2: A clock edge that samples `en_n`=0 with `we_n`=1, after an edge that sampled `en_n`=1, starts a sense. `dq_out` keeps its previous value through the edge `SENSE_CYC`-1 edges later. After the edge `SENSE_CYC` edges later it shows the stored word at the sampled address.
- R3: A change of `addr` sampled while `en_n`=0 and `we_n`=1 starts a sense, with the same timing as R2.
- R4: When no sense completes, `dq_out` does not change. Rewriting the currently latched address with the address held steady leaves `dq_out` at the old word.
- R5: A trigger on the edge right after a sense start (sense age below `MERGE_CYC`=1) merges into that sense. Only one result is produced: the word at the newer address, on the original schedule, with `rd_err`=0.
- R6: A trigger arriving at sense age `MERGE_CYC` or later restarts the sense. After `SENSE_CYC` further edges, `rd_err` is 1 and `dq_out` is all ones. The next clean sense clears `rd_err` and shows the stored word.
- R7: One edge after sampling, `dq_oe` is 1 exactly when `en_n`=0, `we_n`=1 and `oe_n`=0. Otherwise it is 0, which covers standby, outputs disabled, and writing.
- R8: An edge that samples `en_n`=0 and `we_n`=0 stores `wdata` at `addr`, whatever `oe_n` is. Every location reads back what was written to it.
- R9: Address changes while `en_n`=1 start no sense. After standby, the latched word is still on `dq_out` until a sense started by re-enabling completes.
- R10: With `en_n`=0, `we_n`=1 and `oe_n`=1 the die still senses while its outputs stay off. Lowering `oe_n` afterwards presents the sensed word one edge later, with no new sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Die enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| dq_out | output | DATA_W | Latched read word (all ones after a damaged read) |
| dq_oe | output | 1 | Data bus drive enable, registered |
| rd_err | output | 1 | Last completed sense was damaged by a late trigger |

## Verification
The assertions take it that the inputs are clean synchronous levels sampled once per edge. They also take `MERGE_CYC` to be below `SENSE_CYC`, so that a merge can never coincide with the loading edge. The stimulus drives every input on the falling edge and keeps the default window sizes. It spaces reads `SENSE_CYC`+1 edges apart, except where a merge or a late trigger is the point of the test. In the output-enable sweep, write cycles put back the word a location already holds, so the array contents stay known.

// File: rtl/sense_pkg.sv
package sense_pkg;
  typedef enum logic {
    SENSE_IDLE = 1'b0,
    SENSE_RUN  = 1'b1
  } sense_st_e;
endpackage

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              trig
);
  logic              prev_en_n;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en_n <= 1'b1;
      prev_addr <= '0;
    end else begin
      prev_en_n <= en_n;
      prev_addr <= addr;
    end
  end

  // enable edge and address edge requests are ORed into one trigger
  assign trig = !en_n && we_n && (prev_en_n || (addr != prev_addr));
endmodule

// File: rtl/sense_ctrl.sv
module sense_ctrl
  import sense_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SENSE_CYC = 3,
  parameter int MERGE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              bad,
  output logic [ADDR_W-1:0] s_addr
);
  localparam int AGW = $clog2(SENSE_CYC + 1);
  localparam logic [AGW-1:0] LAST_AGE  = AGW'(SENSE_CYC - 1);
  localparam logic [AGW-1:0] MERGE_AGE = AGW'(MERGE_CYC);

  sense_st_e      st;
  logic [AGW-1:0] age;
  logic           late;

  assign late = (st == SENSE_RUN) && trig && (age >= MERGE_AGE);
  assign load = (st == SENSE_RUN) && (age == LAST_AGE) && !late;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SENSE_IDLE;
      age    <= '0;
      s_addr <= '0;
      bad    <= 1'b0;
    end else if (st == SENSE_IDLE) begin
      if (trig) begin
        st     <= SENSE_RUN;
        age    <= '0;
        s_addr <= addr;
        bad    <= 1'b0;
      end
    end else if (late) begin
      age    <= '0;
      s_addr <= addr;
      bad    <= 1'b1;
    end else begin
      if (trig) s_addr <= addr;
      if (age == LAST_AGE) st <= SENSE_IDLE;
      else age <= age + 1'b1;
    end
  end

  AST_AGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == SENSE_RUN) |-> (age < AGW'(SENSE_CYC))); // R2
  AST_NO_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    (st == SENSE_IDLE && !trig) |=> (st == SENSE_IDLE)); // R9
  AST_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    load |=> (st == SENSE_IDLE)); // R5
endmodule

// File: rtl/word_array.sv
module word_array #(
  parameter int DATA_W = 39,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (rd) q <= mem[raddr];
  end
endmodule

// File: rtl/trig_sense_sram.sv
module trig_sense_sram #(
  parameter int DATA_W    = 39,
  parameter int ADDR_W    = 6,
  parameter int SENSE_CYC = 3,
  parameter int MERGE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rd_err
);
  logic              trig;
  logic              load;
  logic              bad;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] q;

  trig_detect #(.ADDR_W(ADDR_W)) u_trig (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n), .addr(addr), .trig(trig)
  );

  sense_ctrl #(.ADDR_W(ADDR_W), .SENSE_CYC(SENSE_CYC), .MERGE_CYC(MERGE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .addr(addr),
    .load(load), .bad(bad), .s_addr(s_addr)
  );

  word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst(rst),
    .wr(!en_n && !we_n), .waddr(addr), .wdata(wdata),
    .rd(load && !bad), .raddr(s_addr), .q(q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      dq_oe <= !en_n && we_n && !oe_n;
      if (load) rd_err <= bad;
    end
  end

  assign dq_out = rd_err ? '1 : q;

  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (rst)
    (en_n || !we_n) |=> !dq_oe); // R7
  AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_err) |-> $past(load)); // R6
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dq_out)); // R4
endmodule

// File: tb/trig_sense_sram_bench.sv
module trig_sense_sram_bench;
  localparam int DW = 39;
  localparam int AW = 6;
  localparam int SC = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, rd_err;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] last;

  always #10 clk = ~clk;

  trig_sense_sram u_trig_sense_sram (
    .clk(clk), .rst(rst), .en_n(en_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe), .rd_err(rd_err)
  );

  function automatic logic [DW-1:0] pat(int a, int s);
    return (DW'(a) * DW'(39'h24F1B)) ^ (DW'(s) << 24) ^ DW'(39'h15);
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    chk("R1 oe in reset", 64'(dq_oe), 64'd0);
    rst = 1'b0;
    chk("R1 dq_out", 64'(dq_out), 64'd0);
    chk("R1 rd_err", 64'(rd_err), 64'd0);
    cyc();
    chk("R1 oe after reset", 64'(dq_oe), 64'd0);
    last = '0;

    // R8: fill every location, output enable high on odd words
    for (int a = 0; a < DEPTH; a++) begin
      exp_mem[a] = pat(a, 1);
      en_n = 1'b0; we_n = 1'b0; oe_n = a[0]; addr = AW'(a); wdata = exp_mem[a];
      cyc();
      chk("R7 oe during write", 64'(dq_oe), 64'd0);
    end
    en_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    cyc();

    // R2: enable-triggered reads of every address
    for (int a = 0; a < DEPTH; a++) begin
      en_n = 1'b1; cyc();
      en_n = 1'b0; addr = AW'(a);
      repeat (SC) cyc();
      chk("R2 before sense ends", 64'(dq_out), 64'(last));
      chk("R7 read drives", 64'(dq_oe), 64'd1);
      cyc();
      chk("R8 word readback", 64'(dq_out), 64'(exp_mem[a]));
      chk("R2 no err", 64'(rd_err), 64'd0);
      last = exp_mem[a];
    end

    // R3: address-triggered reads while enabled
    for (int i = 0; i < DEPTH; i++) begin
      int a = (i * 5 + 1) % DEPTH;
      addr = AW'(a);
      repeat (SC) cyc();
      chk("R3 before sense ends", 64'(dq_out), 64'(last));
      cyc();
      chk("R3 address access", 64'(dq_out), 64'(exp_mem[a]));
      last = exp_mem[a];
    end

    // R4: rewrite the latched address, no new trigger
    addr = 6'd5; repeat (SC + 1) cyc(); last = exp_mem[5];
    chk("R4 setup", 64'(dq_out), 64'(last));
    we_n = 1'b0; wdata = pat(5, 7); cyc();
    exp_mem[5] = pat(5, 7);
    we_n = 1'b1; repeat (6) cyc();
    chk("R4 stale hold", 64'(dq_out), 64'(last));
    addr = 6'd6; repeat (SC + 1) cyc();
    addr = 6'd5; repeat (SC + 1) cyc();
    chk("R4 new word after retrigger", 64'(dq_out), 64'(exp_mem[5]));
    last = exp_mem[5];

    // R5: merged triggers
    addr = 6'd12; cyc();
    addr = 6'd13; cyc();
    repeat (SC - 2) cyc();
    chk("R5 before merged sense ends", 64'(dq_out), 64'(last));
    cyc();
    chk("R5 merged result", 64'(dq_out), 64'(exp_mem[13]));
    chk("R5 no err", 64'(rd_err), 64'd0);
    last = exp_mem[13];

    // R6: late trigger
    addr = 6'd20; cyc(); cyc();
    addr = 6'd21; cyc();
    repeat (SC - 1) cyc();
    chk("R6 before damaged end", 64'(dq_out), 64'(last));
    chk("R6 err not yet", 64'(rd_err), 64'd0);
    cyc();
    chk("R6 err set", 64'(rd_err), 64'd1);
    chk("R6 all ones", 64'(dq_out), 64'({DW{1'b1}}));
    addr = 6'd22; repeat (SC + 1) cyc();
    chk("R6 err cleared", 64'(rd_err), 64'd0);
    chk("R6 clean word", 64'(dq_out), 64'(exp_mem[22]));

    // R7: output-enable truth table
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c = 3'(i);
      en_n = c[2]; we_n = c[1]; oe_n = c[0]; wdata = exp_mem[addr];
      cyc();
      chk("R7 truth table", 64'(dq_oe), 64'(!c[2] && c[1] && !c[0]));
    end
    en_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; repeat (6) cyc();

    // R9: standby address changes start nothing
    en_n = 1'b0; addr = 6'd10; repeat (SC + 1) cyc();
    last = exp_mem[10];
    chk("R9 setup", 64'(dq_out), 64'(last));
    en_n = 1'b1;
    for (int a = 40; a < 45; a++) begin
      addr = AW'(a); cyc();
      chk("R9 standby off", 64'(dq_oe), 64'd0);
    end
    chk("R9 no err in standby", 64'(rd_err), 64'd0);
    en_n = 1'b0; addr = 6'd30;
    repeat (SC) cyc();
    chk("R9 held after standby", 64'(dq_out), 64'(last));
    cyc();
    chk("R9 read after standby", 64'(dq_out), 64'(exp_mem[30]));

    // R10: sensing with outputs disabled
    en_n = 1'b1; cyc();
    en_n = 1'b0; oe_n = 1'b1; addr = 6'd50;
    repeat (SC + 1) cyc();
    chk("R10 outputs off", 64'(dq_oe), 64'd0);
    oe_n = 1'b0; cyc();
    chk("R10 outputs on", 64'(dq_oe), 64'd1);
    chk("R10 sensed word", 64'(dq_out), 64'(exp_mem[50]));

    finish_run();
  end
endmodule